// File: doc/BRIEF.md
# Configurable Rotate and Shift Unit

This block is a purely combinational word shifter. It takes a data word, a binary selector and a two-bit mode code, and drives a shifted copy of the word on its output within the same evaluation. No clock or state is involved. Every output bit has its own selector, and the wiring of those selectors is what implements each operation.

Three behaviours are offered. The first is a barrel rotate that moves the word toward the most significant end by the selector amount, with bits wrapping around. The second is a barrel logical shift by the same amount, in which vacated low bits become zero. The third is a single-step mode: the top selector bit enables a one-position move and the next bit picks its direction. The fourth mode code passes the word through untouched. The word width is a power-of-two parameter of at least 4, and the selector is log2 of that width.

Top module: `shift_rotate_unit`

## Requirements
- R1: With modeSel = 0 (rotate), dataOut[i] = dataIn[(i - selIn) mod WIDTH] for every bit i and every selector value.
- R2: At WIDTH = 4 with modeSel = 0 and selIn = 2, dataOut bits 3..0 equal dataIn bits 1,0,3,2 in that order.
- R3: With modeSel = 1 (logical shift), dataOut[i] = dataIn[i - selIn] when i >= selIn and dataOut[i] = 0 when i < selIn.
- R4: With modeSel = 2 (single step) and selIn bit 1 = 0, dataOut equals dataIn whatever selIn bit 0 is.
- R5: With modeSel = 2 and selIn[1:0] = 2'b10, dataOut[i] = dataIn[i-1] for i >= 1, dataOut[0] = 0, and the old top bit is discarded.
- R6: With modeSel = 2 and selIn[1:0] = 2'b11, dataOut[i] = dataIn[i+1] for i < WIDTH-1, dataOut[WIDTH-1] = 0, and the old bit 0 is discarded.
- R7: With modeSel = 3, dataOut equals dataIn for every selector value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | WIDTH | Word to be rotated or shifted |
| selIn | input | log2(WIDTH) | Distance in the barrel modes; bit 1 = enable and bit 0 = direction (1 = right) in single-step mode |
| modeSel | input | 2 | 0 rotate, 1 logical shift, 2 single step, 3 pass-through |
| dataOut | output | WIDTH | Result word |

## Verification
The boundary where the barrel distance equals the bit index is the hardest point to reach. An output bit switches there from receiving zero fill to carrying an input bit, and only a word with a one in exactly the right position reveals an off-by-one. The bench therefore sweeps every input word against every selector value in each mode. This guarantees that each output bit sees a one arrive from each tap of its selector, and in rollout mode from each side of the fill boundary. Both end bits of the single-step mode are covered by the same exhaustive sweep.

// File: rtl/shift_rotate_pkg.sv
`timescale 1ns/1ps
package shift_rotate_pkg;

  typedef enum logic [1:0] {
    MODE_ROTATE = 2'd0,
    MODE_LSHIFT = 2'd1,
    MODE_STEP   = 2'd2,
    MODE_PASS   = 2'd3
  } mode_t;

  // Strobes from the control decode to the bit selectors
  typedef struct packed {
    logic barrelOn;   // use the selector value as a shift distance
    logic zeroFill;   // barrel: replace wrapped bits with zero
    logic stepOn;     // single-position move enabled
    logic stepRight;  // single-position move toward bit 0
  } strobe_t;

endpackage

// File: rtl/shift_rotate_ctrl.sv
`timescale 1ns/1ps
module shift_rotate_ctrl
  import shift_rotate_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic [1:0]       modeSel,
  input  logic [SEL_W-1:0] selIn,
  output strobe_t          strobes
);

  always_comb begin
    strobes = '0;
    unique case (mode_t'(modeSel))
      MODE_ROTATE: strobes.barrelOn = 1'b1;
      MODE_LSHIFT: begin
        strobes.barrelOn = 1'b1;
        strobes.zeroFill = 1'b1;
      end
      MODE_STEP: begin
        strobes.stepOn    = selIn[1];
        strobes.stepRight = selIn[0];
      end
      default: strobes = '0;
    endcase
  end

  // The pass-through code must never request a move of any kind
  always_comb begin
    if (!$isunknown(modeSel) && modeSel == 2'd3) begin
      p_pass_code_quiet_r7: assert (!strobes.barrelOn && !strobes.stepOn);
    end
  end

endmodule

// File: rtl/shift_rotate_datapath.sv
`timescale 1ns/1ps
module shift_rotate_datapath
  import shift_rotate_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int SEL_W = 2
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [SEL_W-1:0] selIn,
  input  strobe_t          strobes,
  output logic [WIDTH-1:0] dataOut
);

  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    // tap[m] carries the input bit that lands here after a move of m
    logic [WIDTH-1:0] tap;
    logic fromBelow, fromAbove, barrelBit;

    for (genvar m = 0; m < WIDTH; m++) begin : g_tap
      assign tap[m] = dataIn[(j - m + WIDTH) % WIDTH];
    end

    if (j == 0) begin : g_low_end
      assign fromBelow = 1'b0;
    end else begin : g_low_mid
      assign fromBelow = dataIn[j-1];
    end

    if (j == WIDTH - 1) begin : g_high_end
      assign fromAbove = 1'b0;
    end else begin : g_high_mid
      assign fromAbove = dataIn[j+1];
    end

    always_comb begin
      barrelBit = tap[selIn];
      if (strobes.zeroFill && (int'(selIn) > j)) barrelBit = 1'b0;
    end

    always_comb begin
      if (strobes.barrelOn)    dataOut[j] = barrelBit;
      else if (strobes.stepOn) dataOut[j] = strobes.stepRight ? fromAbove : fromBelow;
      else                     dataOut[j] = dataIn[j];
    end
  end

  // Checks on the assembled word against its source
  logic [WIDTH-1:0] lowMask;
  always_comb lowMask = WIDTH'((1 << selIn) - 1);

  always_comb begin
    if (!$isunknown({dataIn, selIn, strobes})) begin
      if (strobes.barrelOn && !strobes.zeroFill)
        p_rotate_keeps_weight_r1: assert ($countones(dataOut) == $countones(dataIn));
      if (strobes.barrelOn && selIn == '0)
        p_zero_distance_identity_r1: assert (dataOut == dataIn);
      if (strobes.barrelOn && strobes.zeroFill)
        p_rollout_low_clear_r3: assert ((dataOut & lowMask) == '0);
      if (strobes.stepOn && !strobes.stepRight)
        p_step_left_fill_r5: assert (dataOut[0] == 1'b0);
      if (strobes.stepOn && strobes.stepRight)
        p_step_right_fill_r6: assert (dataOut[WIDTH-1] == 1'b0);
      if (!strobes.barrelOn && !strobes.stepOn)
        p_idle_passes_word_r4: assert (dataOut == dataIn);
    end
  end

endmodule

// File: rtl/shift_rotate_unit.sv
`timescale 1ns/1ps
module shift_rotate_unit
  import shift_rotate_pkg::*;
#(
  parameter int WIDTH = 4,
  localparam int SEL_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [SEL_W-1:0] selIn,
  input  logic [1:0]       modeSel,
  output logic [WIDTH-1:0] dataOut
);

  strobe_t strobes;

  shift_rotate_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .modeSel (modeSel),
    .selIn   (selIn),
    .strobes (strobes)
  );

  shift_rotate_datapath #(.WIDTH(WIDTH), .SEL_W(SEL_W)) u_datapath (
    .dataIn  (dataIn),
    .selIn   (selIn),
    .strobes (strobes),
    .dataOut (dataOut)
  );

endmodule

// File: tb/shift_rotate_unit_bench.sv
`timescale 1ns/1ps
module shift_rotate_unit_bench;

  localparam int W  = 4;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [W-1:0]  dataIn = '0;
  logic [SW-1:0] selIn = '0;
  logic [1:0]    modeSel = 2'd3;
  logic [W-1:0]  dataOut;
  int            nChecks = 0;
  int            nFails = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  shift_rotate_unit #(.WIDTH(W)) u_shift_rotate_unit (
    .dataIn  (dataIn),
    .selIn   (selIn),
    .modeSel (modeSel),
    .dataOut (dataOut)
  );

  task automatic drive(input logic [W-1:0] a, input logic [SW-1:0] s, input logic [1:0] m);
    @(negedge clk);
    dataIn = a; selIn = s; modeSel = m;
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] expected);
    nChecks++;
    if (dataOut !== expected) begin
      nFails++;
      $display("FAIL %s: in=%b sel=%0d mode=%0d actual=%b expected=%b",
               req, dataIn, selIn, modeSel, dataOut, expected);
    end
  endtask

  // Quiet start: zero word, pass-through code (R7)
  task automatic t_start_state;
    drive('0, '0, 2'd3);
    check("R7 start", '0);
  endtask

  task automatic t_rotate_sweep;  // R1
    for (int a = 0; a < 16; a++)
      for (int j = 0; j < W; j++) begin
        logic [W-1:0] v, e;
        v = W'(a);
        e = (v << j) | (v >> (W - j));
        drive(v, SW'(j), 2'd0);
        check("R1 rotate", e);
      end
  endtask

  task automatic t_rotate_example;  // R2
    drive(4'b1100, 2'd2, 2'd0);
    check("R2 example", 4'b0011);
    drive(4'b1001, 2'd2, 2'd0);
    check("R2 example", 4'b0110);
    drive(4'b0010, 2'd2, 2'd0);
    check("R2 example", 4'b1000);
  endtask

  task automatic t_rollout_sweep;  // R3
    for (int a = 0; a < 16; a++)
      for (int j = 0; j < W; j++) begin
        logic [W-1:0] v, e;
        v = W'(a);
        e = v << j;
        drive(v, SW'(j), 2'd1);
        check("R3 rollout", e);
      end
  endtask

  task automatic t_step_hold;  // R4
    for (int a = 0; a < 16; a++)
      for (int d = 0; d < 2; d++) begin
        drive(W'(a), SW'(d), 2'd2);
        check("R4 step disabled", W'(a));
      end
  endtask

  task automatic t_step_left;  // R5
    for (int a = 0; a < 16; a++) begin
      logic [W-1:0] v;
      v = W'(a);
      drive(v, 2'b10, 2'd2);
      check("R5 step left", v << 1);
    end
  endtask

  task automatic t_step_right;  // R6
    for (int a = 0; a < 16; a++) begin
      logic [W-1:0] v;
      v = W'(a);
      drive(v, 2'b11, 2'd2);
      check("R6 step right", v >> 1);
    end
  endtask

  task automatic t_pass_code;  // R7
    for (int a = 0; a < 16; a++)
      for (int j = 0; j < W; j++) begin
        drive(W'(a), SW'(j), 2'd3);
        check("R7 pass", W'(a));
      end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    t_start_state();
    t_rotate_sweep();
    t_rotate_example();
    t_rollout_sweep();
    t_step_hold();
    t_step_left();
    t_step_right();
    t_pass_code();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule